// File: doc/BRIEF.md
# RAM-Coefficient Decimating FIR Filter

This block is the last channel-filter stage of a digital receive path. It takes complex baseband samples (I and Q) with a valid strobe. Every D-th accepted sample starts one output computation: a sum of products over the newest T samples, with coefficients held in a writable RAM. One multiplier per lane is reused across the taps, one tap per clock cycle. Fewer clock cycles between outputs therefore leave room for fewer taps. The I and Q lanes run in parallel and use the same coefficients.

The result is rounded and saturated to the output width. In bypass mode the stage forwards each input sample unchanged. Coefficients are loaded through a plain write port. A write lands only when no output computation is in flight, or while reset is held. If an output falls due while the previous one is still being computed, the new output is dropped and a sticky overrun flag is set.

Top module: `rcf_decim_fir`

## Requirements
- R1: With `cfg_bypass` high, every accepted input appears on the outputs one clock later, sign-extended to the output width, with `out_valid` high for one cycle. Bypassed samples still enter the delay line, and the decimation count does not advance.
- R2: With `cfg_bypass` low, an output computation starts only on every D-th accepted input, where D = `cfg_dec_m1` + 1 (code 0 gives D = 1, code 255 gives D = 256). The count starts from zero after reset.
- R3: The output for the triggering sample x[n] is the sum over k = 0..T-1 of h[k]·x[n-k]. Here T = `cfg_taps_m1` + 1, clamped to at most 160. h[k] is the 20-bit two's-complement coefficient at address k, with 19 fraction bits.
- R4: The accumulated sum is rounded half up: result = floor((acc + 2^18) / 2^19).
- R5: A rounded result outside the signed 16-bit range is saturated to 32767 or -32768.
- R6: The I and Q lanes use the same coefficients and are computed independently, with no cross terms.
- R7: A computation occupies exactly T consecutive issue cycles. Its result becomes visible after the (T+3)-th rising edge following the edge that sampled the triggering input. Filter outputs are never valid in two consecutive cycles.
- R8: If an output falls due while a computation is running, it is dropped and `overrun` rises. `overrun` stays high until reset.
- R9: A coefficient write is performed only while reset is high, or while no computation or pipeline stage is active. At any other time it is ignored. Addresses of 160 and above are ignored.
- R10: While reset is high, `out_valid`, `overrun`, `out_i` and `out_q` are driven to zero by the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bypass | input | 1 | Forward samples unfiltered when high |
| cfg_taps_m1 | input | 8 | Tap count minus one (clamped to 159) |
| cfg_dec_m1 | input | 8 | Decimation factor minus one |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 8 | Coefficient (tap) index |
| coef_data | input | 20 | Signed coefficient, 19 fraction bits |
| in_valid | input | 1 | Input sample strobe |
| in_i | input | 16 | Signed in-phase input |
| in_q | input | 16 | Signed quadrature input |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | 16 | Signed in-phase output |
| out_q | output | 16 | Signed quadrature output |
| overrun | output | 1 | Sticky flag for a dropped output |

## Verification
The bound assertions check the following on every cycle:
- the bypass echo and its one-cycle timing;
- that `overrun` stays set, and that it rises only when a computation is due while one is running;
- that each issue sequence lasts exactly the latched tap count;
- that filter outputs are never back to back;
- the reset values.

The arithmetic can only be shown by the bench's scenarios. These cover the sum of products, round-half-up on negative halves, saturation at both rails and the I/Q independence. The same holds for the decimation counts at D = 1, 2 and 256, the tap clamp, and whether a coefficient write issued mid-computation was dropped. The bench judges all of these from output values, against its own model of the delay line and the coefficients.

// File: rtl/rcf_pkg.sv
package rcf_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  // Number of parallel datapath lanes (I and Q).
  localparam int NLANE = 2;

  // Tag travelling alongside each issued tap through the pipeline.
  typedef struct packed {
    logic vld;
    logic first;
    logic last;
  } rcf_tag_t;
endpackage

// File: rtl/rcf_coef_ram.sv
module rcf_coef_ram #(
  parameter int CW    = 20,
  parameter int DEPTH = 160,
  parameter int AW    = 8
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic signed [CW-1:0] wdata,
  input  logic [AW-1:0]        raddr,
  output logic signed [CW-1:0] rdata
);
  timeunit 1ns;
  timeprecision 1ps;

  logic signed [CW-1:0] mem [DEPTH];

  // Simple dual-port: one write port, one registered read port.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rcf_sample_ram.sv
module rcf_sample_ram #(
  parameter int WW    = 32,
  parameter int DEPTH = 320,
  parameter int AW    = 9
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [WW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [WW-1:0] rdata
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [WW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rcf_seq_ctrl.sv
module rcf_seq_ctrl
  import rcf_pkg::*;
#(
  parameter int MAX_TAPS = 160,
  parameter int DEPTH    = 320,
  parameter int TW       = 8,
  parameter int SAW      = 9,
  parameter int DECW     = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic            cfg_bypass,
  input  logic [TW-1:0]   cfg_taps_m1,
  input  logic [DECW-1:0] cfg_dec_m1,
  output logic [SAW-1:0]  smp_waddr,
  output logic [SAW-1:0]  smp_raddr,
  output logic [TW-1:0]   coef_raddr,
  output rcf_tag_t        iss,
  output logic            busy,
  output logic [TW-1:0]   tlast,
  output logic            overrun
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam logic [TW-1:0]  TAP_CAP = TW'(MAX_TAPS - 1);
  localparam logic [SAW-1:0] TOP_IDX = SAW'(DEPTH - 1);

  logic [SAW-1:0]  wptr;
  logic [SAW-1:0]  rptr;
  logic [TW-1:0]   k;
  logic [DECW-1:0] dcnt;
  logic            trig;
  logic [TW-1:0]   taps_lim;

  // An output falls due on the D-th filter-mode input.
  assign trig     = in_valid && !cfg_bypass && (dcnt >= cfg_dec_m1);
  assign taps_lim = (cfg_taps_m1 > TAP_CAP) ? TAP_CAP : cfg_taps_m1;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr    <= '0;
      rptr    <= '0;
      k       <= '0;
      dcnt    <= '0;
      busy    <= 1'b0;
      tlast   <= '0;
      overrun <= 1'b0;
    end else begin
      if (in_valid) wptr <= (wptr == TOP_IDX) ? '0 : wptr + 1'b1;
      if (in_valid && !cfg_bypass) dcnt <= trig ? '0 : dcnt + 1'b1;
      if (busy) begin
        k    <= k + 1'b1;
        rptr <= (rptr == '0) ? TOP_IDX : rptr - 1'b1;
        if (k == tlast) busy <= 1'b0;
      end
      if (trig) begin
        if (busy) begin
          overrun <= 1'b1;
        end else begin
          busy  <= 1'b1;
          k     <= '0;
          rptr  <= wptr;
          tlast <= taps_lim;
        end
      end
    end
  end

  assign smp_waddr  = wptr;
  assign smp_raddr  = rptr;
  assign coef_raddr = k;
  assign iss.vld    = busy;
  assign iss.first  = (k == '0);
  assign iss.last   = (k == tlast);
endmodule

// File: rtl/rcf_mac_lane.sv
module rcf_mac_lane #(
  parameter int DW    = 16,
  parameter int CW    = 20,
  parameter int OW    = 16,
  parameter int ACCW  = 44,
  parameter int SHIFT = 19
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 mul_en,
  input  logic                 acc_en,
  input  logic                 acc_first,
  input  logic signed [DW-1:0] smp,
  input  logic signed [CW-1:0] coef,
  output logic signed [OW-1:0] res
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PW = DW + CW;
  localparam logic signed [ACCW:0] HALF = (ACCW+1)'(1) <<< (SHIFT - 1);
  localparam logic signed [ACCW:0] OMAX = (ACCW+1)'((64'sd1 <<< (OW - 1)) - 1);
  localparam logic signed [ACCW:0] OMIN = -OMAX - 1;

  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] acc;
  logic signed [ACCW:0]   rnd;
  logic signed [ACCW:0]   sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      prod <= '0;
      acc  <= '0;
    end else begin
      if (mul_en) prod <= smp * coef;
      if (acc_en) acc <= acc_first ? ACCW'(prod) : acc + ACCW'(prod);
    end
  end

  // Round half up, then clip to the output range.
  always_comb begin
    rnd = (ACCW+1)'(acc) + HALF;
    sh  = rnd >>> SHIFT;
    if (sh > OMAX)      res = OW'(OMAX);
    else if (sh < OMIN) res = OW'(OMIN);
    else                res = OW'(sh);
  end
endmodule

// File: rtl/rcf_decim_fir.sv
module rcf_decim_fir
  import rcf_pkg::*;
#(
  parameter int DW       = 16,
  parameter int CW       = 20,
  parameter int OW       = 16,
  parameter int MAX_TAPS = 160,
  parameter int DECW     = 8,
  parameter int SHIFT    = CW - 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_bypass,
  input  logic [$clog2(MAX_TAPS)-1:0] cfg_taps_m1,
  input  logic [DECW-1:0]      cfg_dec_m1,
  input  logic                 coef_we,
  input  logic [$clog2(MAX_TAPS)-1:0] coef_addr,
  input  logic signed [CW-1:0] coef_data,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_i,
  input  logic signed [DW-1:0] in_q,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_i,
  output logic signed [OW-1:0] out_q,
  output logic                 overrun
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int TW    = $clog2(MAX_TAPS);
  localparam int DEPTH = 2 * MAX_TAPS;
  localparam int SAW   = $clog2(DEPTH);
  localparam int ACCW  = DW + CW + TW;

  logic [SAW-1:0]       smp_waddr, smp_raddr;
  logic [TW-1:0]        coef_raddr;
  logic [TW-1:0]        seq_tlast;
  logic                 seq_busy;
  rcf_tag_t             iss, t1, t2;
  logic                 t3_vld, t3_last;
  logic                 busy_any;
  logic                 coef_ok;
  logic [2*DW-1:0]      smp_word;
  logic signed [CW-1:0] coef_rd;
  logic signed [DW-1:0] lane_smp [NLANE];
  logic signed [OW-1:0] lane_res [NLANE];

  rcf_seq_ctrl #(
    .MAX_TAPS(MAX_TAPS), .DEPTH(DEPTH), .TW(TW), .SAW(SAW), .DECW(DECW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .cfg_bypass(cfg_bypass),
    .cfg_taps_m1(cfg_taps_m1), .cfg_dec_m1(cfg_dec_m1),
    .smp_waddr(smp_waddr), .smp_raddr(smp_raddr), .coef_raddr(coef_raddr),
    .iss(iss), .busy(seq_busy), .tlast(seq_tlast), .overrun(overrun)
  );

  rcf_sample_ram #(.WW(2*DW), .DEPTH(DEPTH), .AW(SAW)) u_dly (
    .clk(clk), .we(in_valid), .waddr(smp_waddr), .wdata({in_i, in_q}),
    .raddr(smp_raddr), .rdata(smp_word)
  );

  // Coefficient writes land only when nothing reads the RAM.
  assign busy_any = seq_busy | t1.vld | t2.vld | t3_vld;
  assign coef_ok  = coef_we && (coef_addr < TW'(MAX_TAPS)) && (rst || !busy_any);

  rcf_coef_ram #(.CW(CW), .DEPTH(MAX_TAPS), .AW(TW)) u_coef (
    .clk(clk), .we(coef_ok), .waddr(coef_addr), .wdata(coef_data),
    .raddr(coef_raddr), .rdata(coef_rd)
  );

  // Tag pipeline: RAM read, multiply, accumulate.
  always_ff @(posedge clk) begin
    if (rst) begin
      t1      <= '0;
      t2      <= '0;
      t3_vld  <= 1'b0;
      t3_last <= 1'b0;
    end else begin
      t1      <= iss;
      t2      <= t1;
      t3_vld  <= t2.vld;
      t3_last <= t2.last;
    end
  end

  assign lane_smp[0] = smp_word[2*DW-1:DW];
  assign lane_smp[1] = smp_word[DW-1:0];

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    rcf_mac_lane #(
      .DW(DW), .CW(CW), .OW(OW), .ACCW(ACCW), .SHIFT(SHIFT)
    ) u_lane (
      .clk(clk), .rst(rst), .mul_en(t1.vld), .acc_en(t2.vld),
      .acc_first(t2.first), .smp(lane_smp[g]), .coef(coef_rd),
      .res(lane_res[g])
    );
  end

  // Registered output; a bypassed sample takes priority.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= 1'b0;
      if (in_valid && cfg_bypass) begin
        out_valid <= 1'b1;
        out_i     <= OW'(in_i);
        out_q     <= OW'(in_q);
      end else if (t3_vld && t3_last) begin
        out_valid <= 1'b1;
        out_i     <= lane_res[0];
        out_q     <= lane_res[1];
      end
    end
  end
endmodule

// File: rtl/rcf_decim_fir_chk.sv
module rcf_decim_fir_chk #(
  parameter int DW = 16,
  parameter int OW = 16,
  parameter int TW = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 cfg_bypass,
  input logic signed [DW-1:0] in_i,
  input logic signed [DW-1:0] in_q,
  input logic                 out_valid,
  input logic signed [OW-1:0] out_i,
  input logic signed [OW-1:0] out_q,
  input logic                 overrun,
  input logic                 busy,
  input logic [TW-1:0]        tlast
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [TW:0] run_len;

  always_ff @(posedge clk) begin
    if (rst) run_len <= '0;
    else     run_len <= busy ? run_len + 1'b1 : '0;
  end

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (!out_valid && !overrun && out_i == '0 && out_q == '0));

  assert_bypass_echo_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cfg_bypass) |=>
      (out_valid && out_i == OW'($past(in_i)) && out_q == OW'($past(in_q))));

  assert_overrun_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(in_valid && !cfg_bypass && busy));

  assert_issue_length_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (run_len == {1'b0, tlast} + 1'b1));

  assert_output_spacing_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !cfg_bypass && !$past(cfg_bypass)) |=> !out_valid);
endmodule

bind rcf_decim_fir rcf_decim_fir_chk #(.DW(DW), .OW(OW), .TW(TW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .cfg_bypass(cfg_bypass),
  .in_i(in_i), .in_q(in_q), .out_valid(out_valid), .out_i(out_i),
  .out_q(out_q), .overrun(overrun), .busy(seq_busy), .tlast(seq_tlast)
);

// File: tb/rcf_decim_fir_bench.sv
module rcf_decim_fir_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               cfg_bypass = 1'b0;
  logic [7:0]         cfg_taps_m1 = 8'd3;
  logic [7:0]         cfg_dec_m1 = 8'd1;
  logic               coef_we = 1'b0;
  logic [7:0]         coef_addr = '0;
  logic signed [19:0] coef_data = '0;
  logic               in_valid = 1'b0;
  logic signed [15:0] in_i = '0, in_q = '0;
  logic               out_valid;
  logic signed [15:0] out_i, out_q;
  logic               overrun;

  int nchk = 0, nerr = 0, ocount = 0;
  int hi [1024];
  int hq [1024];
  int nh = 0;
  int hc [160];
  bit finished = 0;

  always #2.5 clk = ~clk;

  rcf_decim_fir u_rcf_decim_fir (
    .clk(clk), .rst(rst), .cfg_bypass(cfg_bypass), .cfg_taps_m1(cfg_taps_m1),
    .cfg_dec_m1(cfg_dec_m1), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q), .overrun(overrun)
  );

  always @(negedge clk) if (!rst && out_valid) ocount++;

  // Stimulus: I, Q, expect-output flag, expected I, expected Q (4 taps of 0.5, D=2)
  localparam int TBL [10][5] = '{
    '{100, -50, 0, 0, 0},
    '{200, 30, 1, 150, -10},          // R3 R6 plain sums
    '{-400, 7, 0, 0, 0},
    '{1001, 8, 1, 451, -2},           // R4 negative half rounds up
    '{32767, -32768, 0, 0, 0},
    '{32767, -32768, 1, 32767, -32760}, // R5 positive clip
    '{0, 0, 0, 0, 0},
    '{-3, 5, 1, 32766, -32765},       // R3 R6
    '{-32768, 1, 0, 0, 0},
    '{-32768, 1, 1, -32768, 4}        // R5 negative clip
  };

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint model(input int taps, input bit lane_q);
    longint acc = 0;
    for (int k = 0; k < taps; k++) begin
      int idx = nh - 1 - k;
      longint x = (idx >= 0) ? longint'(lane_q ? hq[idx] : hi[idx]) : 0;
      acc += longint'(hc[k]) * x;
    end
    acc = (acc + 262144) >>> 19;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return acc;
  endfunction

  task automatic record(input int i, input int q);
    hi[nh] = i; hq[nh] = q; nh++;
  endtask

  task automatic send(input int i, input int q);
    @(negedge clk);
    in_valid = 1'b1; in_i = 16'(i); in_q = 16'(q);
    record(i, q);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wcoef(input int a, input int v);
    @(negedge clk);
    coef_we = 1'b1; coef_addr = 8'(a); coef_data = 20'(v);
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic wait_out(output bit got, output int lat);
    got = 0; lat = 0;
    for (int j = 1; j <= 400; j++) begin
      @(posedge clk); #1;
      if (out_valid) begin got = 1; lat = j; break; end
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    bit got;
    int lat, c0;
    longint ei, eq;

    // R9: coefficient load while reset is held; taps 0..3 = 0.5, rest 0
    idle(2);
    for (int k = 0; k < 160; k++) begin
      hc[k] = (k < 4) ? 262144 : 0;
      wcoef(k, hc[k]);
    end
    @(negedge clk); rst = 1'b0;
    // R10 reset state
    check(out_valid == 0 && overrun == 0, "R10 reset flags", {out_valid, overrun}, 0);
    check(out_i == 0 && out_q == 0, "R10 reset data", out_i, 0);

    // R1 bypass echo, then prime the delay line with zeros
    cfg_bypass = 1'b1;
    send(1234, -777);
    check(out_valid && out_i == 1234, "R1 bypass I", out_i, 1234);
    check(out_q == -777, "R1 bypass Q", out_q, -777);
    for (int k = 0; k < 4; k++) send(0, 0);
    idle(2);

    // Table walk: 4 taps, D = 2
    cfg_bypass = 1'b0; cfg_taps_m1 = 8'd3; cfg_dec_m1 = 8'd1;
    idle(2);
    for (int r = 0; r < 10; r++) begin
      c0 = ocount;
      send(TBL[r][0], TBL[r][1]);
      if (TBL[r][2] != 0) begin
        wait_out(got, lat);
        check(got, "R2 output on D-th input", got, 1);
        if (r == 1) check(lat == 7, "R7 latency T+3", lat, 7);
        check(int'(out_i) == TBL[r][3], "R3/R4/R5 table I", out_i, TBL[r][3]);
        check(int'(out_q) == TBL[r][4], "R3/R4/R5/R6 table Q", out_q, TBL[r][4]);
        idle(3);
      end else begin
        idle(12);
        check(ocount == c0, "R2 no output between", ocount - c0, 0);
      end
    end

    // R2: D = 256
    cfg_dec_m1 = 8'd255;
    c0 = ocount;
    for (int k = 0; k < 255; k++) send(1, 1);
    idle(10);
    check(ocount == c0, "R2 D=256 silent for 255", ocount - c0, 0);
    send(1, 1);
    wait_out(got, lat);
    check(got && int'(out_i) == model(4, 0), "R2 D=256 output", out_i, model(4, 0));
    idle(3);

    // R2: D = 1 with a single tap
    cfg_dec_m1 = 8'd0; cfg_taps_m1 = 8'd0;
    send(500, -500);
    wait_out(got, lat);
    check(got && int'(out_i) == model(1, 0), "R2 D=1 I", out_i, model(1, 0));
    check(int'(out_q) == model(1, 1), "R4 D=1 Q", out_q, model(1, 1));
    idle(3);

    // R9: write while busy is ignored
    cfg_taps_m1 = 8'd3;
    @(negedge clk);
    in_valid = 1'b1; in_i = 16'sd2000; in_q = 16'sd100; record(2000, 100);
    @(negedge clk);
    in_valid = 1'b0; coef_we = 1'b1; coef_addr = 8'd0; coef_data = -20'sd262144;
    @(negedge clk);
    coef_we = 1'b0;
    wait_out(got, lat);
    check(got && int'(out_i) == model(4, 0), "R3 busy-run I", out_i, model(4, 0));
    idle(3);
    send(300, 300);
    wait_out(got, lat);
    ei = model(4, 0);
    check(got && int'(out_i) == ei, "R9 busy write ignored", out_i, ei);
    idle(3);

    // R9: write while idle takes effect
    hc[0] = -262144;
    wcoef(0, hc[0]);
    send(300, 300);
    wait_out(got, lat);
    ei = model(4, 0);
    check(got && int'(out_i) == ei, "R9 idle write applied", out_i, ei);
    idle(3);

    // R8 overrun, R3 tap clamp (255 -> 160 taps)
    check(overrun == 0, "R8 no overrun yet", overrun, 0);
    cfg_taps_m1 = 8'd255;
    c0 = ocount;
    @(negedge clk);
    in_valid = 1'b1; in_i = 16'sd4000; in_q = -16'sd4000; record(4000, -4000);
    ei = model(160, 0); eq = model(160, 1);
    @(negedge clk);
    in_i = 16'sd7; in_q = 16'sd7; record(7, 7);
    @(negedge clk);
    in_valid = 1'b0;
    wait_out(got, lat);
    check(got && lat == 162, "R3 clamp to 160 taps (latency)", lat, 162);
    check(int'(out_i) == ei && int'(out_q) == eq, "R8 first output kept", out_i, ei);
    idle(20);
    check(ocount - c0 == 1, "R8 late output dropped", ocount - c0, 1);
    check(overrun == 1, "R8 overrun set", overrun, 1);
    cfg_taps_m1 = 8'd3;
    send(1, 1);
    wait_out(got, lat);
    idle(3);
    check(overrun == 1, "R8 overrun sticky", overrun, 1);

    // R10 / R8 cleared by reset
    @(negedge clk); rst = 1'b1;
    idle(2);
    check(overrun == 0 && out_valid == 0, "R10 R8 reset clears overrun", overrun, 0);
    rst = 1'b0;
    idle(2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule